// File: doc/BRIEF.md
# GPIO Command Source Arbiter

This block sits in front of the register file of a 32-pin GPIO bank that three bus masters can reach: the main CPU, an LPC host and an auxiliary coprocessor. The bank is split into four 8-pin groups, one per byte lane of the 32-bit register word. Each group has a 2-bit owner code. A register write passes to the bank only on the byte lanes whose group is owned by the master that issued the write. Lanes owned by any other master are dropped. The block holds the owner codes itself. Only the main CPU can change them, through a two-word control window.

Each write arrives as one beat on a valid/ready stream. The beat carries a 2-bit master tag, a word address, data and byte strobes. The block never applies back-pressure: `wr_ready` is held high, and a beat is taken on every cycle where `wr_valid` is high. The gated write leaves one cycle later as a registered beat (`out_valid`, `out_addr`, `out_data`, `out_strb`). This output has no ready: the GPIO register file downstream must accept every beat.

Reads carry no master tag and are never gated. The owner codes can be read back combinationally at any time.

Top module: `gpio_cmdsrc_gate`

## Requirements
- R1: After reset every group has owner code 0 (main CPU), both control words read as zero, and `out_valid` and `err_illegal` are low.
- R2: The tags are 0 for the main CPU, 1 for the LPC host, 2 for the coprocessor and 3 for reserved. A write outside the control window with tag t appears one cycle later with `out_strb[g]` = `wr_strb[g]` AND (code of group g == t). The address and data are unchanged.
- R3: When no strobed lane is owned by the writer, the write is dropped entirely and `out_valid` stays low.
- R4: A tag-0 write to word `CS_BASE` sets bit 1 of group g's code from `wr_data[8*g]`. A tag-0 write to word `CS_BASE+1` sets bit 0 of the code from the same data bit. In both cases only lanes with `wr_strb[g]` set are updated, and the new code applies from the next cycle.
- R5: A write to the control window with a tag other than 0 leaves every owner code unchanged.
- R6: A write to the control window is never forwarded on the output.
- R7: A group whose code is 3 accepts no write from any master. A strobed write to such a lane, outside the window, raises `err_illegal` for one cycle, one cycle after the write.
- R8: `rd_data` gives, at bit 8*g, bit 1 of group g's code when `rd_addr` = `CS_BASE` and bit 0 when `rd_addr` = `CS_BASE+1`. All other bits, and every other address, read as zero.
- R9: `wr_ready` is high in every cycle out of reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Write beat present |
| wr_ready | output | 1 | Always high; the block takes every beat |
| wr_tag | input | 2 | Master identity of the beat |
| wr_addr | input | ADDR_W | Word address |
| wr_data | input | 8*LANES | Write data |
| wr_strb | input | LANES | Byte-lane strobes, one per group |
| out_valid | output | 1 | Gated write beat to the GPIO registers |
| out_addr | output | ADDR_W | Forwarded address |
| out_data | output | 8*LANES | Forwarded data |
| out_strb | output | LANES | Lanes the writer owns |
| err_illegal | output | 1 | Pulse: a write touched a lane with code 3 |
| rd_addr | input | ADDR_W | Read address for the control words |
| rd_data | output | 8*LANES | Control word read data |

## Verification
The checks assume that the inputs are held stable through each clock edge, and that the control window does not overlap any GPIO register address that must be forwarded. The stimulus changes inputs only on falling edges and keeps GPIO addresses away from the window. Random writes from any tag may still target the window, and random codes may leave a group at code 3 on purpose. The reference model in the bench tracks ownership with plain integers and predicts every output beat.

// File: rtl/gcsa_pkg.sv
package gcsa_pkg;
  typedef enum logic [1:0] {
    SRC_CPU   = 2'd0,
    SRC_HOST  = 2'd1,
    SRC_COPRO = 2'd2,
    SRC_BAD   = 2'd3
  } src_code_e;

  localparam int LANE_BITS = 8;
endpackage

// File: rtl/gcsa_owner_regs.sv
module gcsa_owner_regs
  import gcsa_pkg::*;
#(
  parameter int LANES  = 4,
  parameter int ADDR_W = 8,
  parameter int CS_BASE = 'h30,
  localparam int DATA_W = LANE_BITS * LANES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              upd_en,
  input  logic [ADDR_W-1:0] upd_addr,
  input  logic [DATA_W-1:0] upd_data,
  input  logic [LANES-1:0]  upd_strb,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic [LANES-1:0]  own_hi,
  output logic [LANES-1:0]  own_lo
);
  localparam logic [ADDR_W-1:0] HI_ADDR = ADDR_W'(CS_BASE);
  localparam logic [ADDR_W-1:0] LO_ADDR = ADDR_W'(CS_BASE + 1);

  // bit 1 of each code lives in the HI word, bit 0 in the LO word
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        own_hi[g] <= 1'b0;
        own_lo[g] <= 1'b0;
      end else if (upd_en && upd_strb[g]) begin
        if (upd_addr == HI_ADDR) own_hi[g] <= upd_data[LANE_BITS*g];
        if (upd_addr == LO_ADDR) own_lo[g] <= upd_data[LANE_BITS*g];
      end
    end
  end

  always_comb begin
    rd_data = '0;
    for (int g = 0; g < LANES; g++) begin
      if (rd_addr == HI_ADDR)      rd_data[LANE_BITS*g] = own_hi[g];
      else if (rd_addr == LO_ADDR) rd_data[LANE_BITS*g] = own_lo[g];
    end
  end
endmodule

// File: rtl/gcsa_lane_gate.sv
module gcsa_lane_gate
  import gcsa_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic [1:0]       tag,
  input  logic [LANES-1:0] strb,
  input  logic [LANES-1:0] own_hi,
  input  logic [LANES-1:0] own_lo,
  output logic [LANES-1:0] lane_en,
  output logic [LANES-1:0] lane_bad
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    src_code_e code;
    assign code        = src_code_e'({own_hi[g], own_lo[g]});
    assign lane_bad[g] = strb[g] && (code == SRC_BAD);
    assign lane_en[g]  = strb[g] && (code != SRC_BAD) && (code == src_code_e'(tag));
  end
endmodule

// File: rtl/gpio_cmdsrc_gate.sv
module gpio_cmdsrc_gate
  import gcsa_pkg::*;
#(
  parameter int LANES   = 4,
  parameter int ADDR_W  = 8,
  parameter int CS_BASE = 'h30,
  localparam int DATA_W = LANE_BITS * LANES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [1:0]        wr_tag,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [LANES-1:0]  wr_strb,
  output logic              out_valid,
  output logic [ADDR_W-1:0] out_addr,
  output logic [DATA_W-1:0] out_data,
  output logic [LANES-1:0]  out_strb,
  output logic              err_illegal,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);
  localparam logic [ADDR_W-1:0] HI_ADDR = ADDR_W'(CS_BASE);
  localparam logic [ADDR_W-1:0] LO_ADDR = ADDR_W'(CS_BASE + 1);

  logic [LANES-1:0] own_hi, own_lo, lane_en, lane_bad;
  logic in_win, to_bank, upd_en;

  assign wr_ready = 1'b1;
  assign in_win   = (wr_addr == HI_ADDR) || (wr_addr == LO_ADDR);
  assign to_bank  = wr_valid && !in_win;
  assign upd_en   = wr_valid && in_win && (src_code_e'(wr_tag) == SRC_CPU);

  gcsa_owner_regs #(
    .LANES(LANES), .ADDR_W(ADDR_W), .CS_BASE(CS_BASE)
  ) owner_i (
    .clk(clk), .rst_n(rst_n),
    .upd_en(upd_en), .upd_addr(wr_addr), .upd_data(wr_data), .upd_strb(wr_strb),
    .rd_addr(rd_addr), .rd_data(rd_data),
    .own_hi(own_hi), .own_lo(own_lo)
  );

  gcsa_lane_gate #(.LANES(LANES)) gate_i (
    .tag(wr_tag), .strb(wr_strb), .own_hi(own_hi), .own_lo(own_lo),
    .lane_en(lane_en), .lane_bad(lane_bad)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_strb    <= '0;
      out_addr    <= '0;
      out_data    <= '0;
      err_illegal <= 1'b0;
    end else begin
      out_valid   <= to_bank && (|lane_en);
      out_strb    <= to_bank ? lane_en : '0;
      err_illegal <= to_bank && (|lane_bad);
      if (to_bank) begin
        out_addr <= wr_addr;
        out_data <= wr_data;
      end
    end
  end
endmodule

// File: rtl/gcsa_checker.sv
module gcsa_checker #(
  parameter int LANES   = 4,
  parameter int ADDR_W  = 8,
  parameter int CS_BASE = 'h30
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_valid,
  input logic [1:0]        wr_tag,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [LANES-1:0]  wr_strb,
  input logic              out_valid,
  input logic [LANES-1:0]  out_strb,
  input logic [LANES-1:0]  own_hi,
  input logic [LANES-1:0]  own_lo
);
  localparam logic [ADDR_W-1:0] HI_ADDR = ADDR_W'(CS_BASE);
  localparam logic [ADDR_W-1:0] LO_ADDR = ADDR_W'(CS_BASE + 1);

  logic win_hit;
  assign win_hit = (wr_addr == HI_ADDR) || (wr_addr == LO_ADDR);

  a_r3_valid_has_lane: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_strb != '0));

  a_r2_lanes_were_strobed: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ((out_strb & ~$past(wr_strb)) == '0));

  a_r5_foreign_owner_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && win_hit && wr_tag != 2'd0) |=> ($stable(own_hi) && $stable(own_lo)));

  a_r6_window_not_forwarded: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && win_hit) |=> !out_valid);

  a_r7_no_illegal_lane: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ((out_strb & $past(own_hi & own_lo)) == '0));
endmodule

bind gpio_cmdsrc_gate gcsa_checker #(
  .LANES(LANES), .ADDR_W(ADDR_W), .CS_BASE(CS_BASE)
) chk_i (
  .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_tag(wr_tag),
  .wr_addr(wr_addr), .wr_strb(wr_strb), .out_valid(out_valid),
  .out_strb(out_strb), .own_hi(own_hi), .own_lo(own_lo)
);

// File: tb/gpio_cmdsrc_gate_tb_top.sv
module gpio_cmdsrc_gate_tb_top;
  localparam int LANES = 4;
  localparam int AW    = 8;
  localparam int DW    = 8 * LANES;
  localparam int BASE  = 'h30;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_valid = 1'b0;
  logic wr_ready;
  logic [1:0] wr_tag = '0;
  logic [AW-1:0] wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic [LANES-1:0] wr_strb = '0;
  logic out_valid, err_illegal;
  logic [AW-1:0] out_addr;
  logic [DW-1:0] out_data;
  logic [LANES-1:0] out_strb;
  logic [AW-1:0] rd_addr = '0;
  logic [DW-1:0] rd_data;

  int n_tests = 0;
  int n_fail  = 0;
  int cycles  = 0;
  bit done    = 0;
  string cur_req = "R1";

  always #10 clk = ~clk;

  gpio_cmdsrc_gate #(.LANES(LANES), .ADDR_W(AW), .CS_BASE(BASE)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_tag(wr_tag), .wr_addr(wr_addr), .wr_data(wr_data), .wr_strb(wr_strb),
    .out_valid(out_valid), .out_addr(out_addr), .out_data(out_data),
    .out_strb(out_strb), .err_illegal(err_illegal),
    .rd_addr(rd_addr), .rd_data(rd_data)
  );

  // behavioural reference model
  int code [LANES];
  bit exp_valid, exp_err;
  int exp_strb;
  logic [AW-1:0] exp_addr;
  logic [DW-1:0] exp_data;

  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (code[g]) code[g] = 0;
      exp_valid = 0; exp_err = 0; exp_strb = 0;
    end else begin
      exp_valid = 0; exp_err = 0; exp_strb = 0;
      if (wr_valid) begin
        if (wr_addr == AW'(BASE) || wr_addr == AW'(BASE + 1)) begin
          if (wr_tag == 2'd0) begin
            for (int g = 0; g < LANES; g++) begin
              if (wr_strb[g]) begin
                if (wr_addr == AW'(BASE)) code[g] = (code[g] & 1) | (int'(wr_data[8*g]) << 1);
                else                      code[g] = (code[g] & 2) | int'(wr_data[8*g]);
              end
            end
          end
        end else begin
          for (int g = 0; g < LANES; g++) begin
            if (wr_strb[g] && code[g] == 3) exp_err = 1;
            if (wr_strb[g] && code[g] != 3 && code[g] == int'(wr_tag)) exp_strb |= (1 << g);
          end
          exp_valid = (exp_strb != 0);
          exp_addr = wr_addr;
          exp_data = wr_data;
        end
      end
    end
  end

  always @(negedge clk) begin
    cycles++;
    if (rst_n && !done) begin
      n_tests++;
      if (out_valid !== exp_valid || out_strb !== LANES'(exp_strb)) begin
        n_fail++;
        $display("FAIL %s: valid/strb actual %b/%b expected %b/%b", cur_req,
                 out_valid, out_strb, exp_valid, LANES'(exp_strb));
      end
      if (exp_valid && (out_addr !== exp_addr || out_data !== exp_data)) begin
        n_fail++;
        $display("FAIL R2: addr/data actual %h/%h expected %h/%h",
                 out_addr, out_data, exp_addr, exp_data);
      end
      n_tests++;
      if (err_illegal !== exp_err) begin
        n_fail++;
        $display("FAIL R7: err_illegal actual %b expected %b", err_illegal, exp_err);
      end
      n_tests++;
      if (wr_ready !== 1'b1) begin
        n_fail++;
        $display("FAIL R9: wr_ready actual %b expected 1", wr_ready);
      end
    end
  end

  task automatic wr(input logic [1:0] tag, input int addr, input logic [DW-1:0] data,
                    input logic [LANES-1:0] strb, input string req);
    @(negedge clk);
    cur_req  = req;
    wr_valid = 1'b1; wr_tag = tag; wr_addr = AW'(addr); wr_data = data; wr_strb = strb;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic chk_rd(input int addr, input logic [DW-1:0] exp, input string req);
    @(negedge clk);
    rd_addr = AW'(addr);
    #1;
    n_tests++;
    if (rd_data !== exp) begin
      n_fail++;
      $display("FAIL %s: rd_data[%0h] actual %h expected %h", req, addr, rd_data, exp);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    chk_rd(BASE, '0, "R1");
    chk_rd(BASE + 1, '0, "R1");
    // R2 CPU owns all; R3 others dropped
    wr(2'd0, 'h10, 32'hA1B2C3D4, 4'b1111, "R2");
    wr(2'd1, 'h10, 32'h11111111, 4'b1111, "R3");
    wr(2'd2, 'h11, 32'h22222222, 4'b0101, "R3");
    // R4: group1 -> host (hi first, then lo), group2 -> coprocessor
    wr(2'd0, BASE,     32'h0000_0000, 4'b0010, "R4");
    wr(2'd0, BASE + 1, 32'h0000_0100, 4'b0010, "R4");
    wr(2'd0, BASE,     32'h0001_0000, 4'b0100, "R4");
    wr(2'd0, BASE + 1, 32'h0000_0000, 4'b0100, "R4");
    chk_rd(BASE,     32'h0001_0000, "R8");
    chk_rd(BASE + 1, 32'h0000_0100, "R8");
    for (int t = 0; t < 4; t++) wr(2'(t), 'h12, 32'h5A5A0000 + t, 4'b1111, "R2");
    wr(2'd1, 'h12, 32'h0, 4'b0001, "R3");
    // R5: foreign write to window ignored
    wr(2'd1, BASE,     32'hFFFF_FFFF, 4'b1111, "R5");
    wr(2'd2, BASE + 1, 32'hFFFF_FFFF, 4'b1111, "R5");
    chk_rd(BASE,     32'h0001_0000, "R5");
    chk_rd(BASE + 1, 32'h0000_0100, "R5");
    // R8: unused bits and other addresses read zero
    wr(2'd0, BASE, 32'hFEFE_FFFE, 4'b0001, "R6");
    chk_rd(BASE, 32'h0001_0000, "R8");
    chk_rd('h10, '0, "R8");
    // R7: group3 to illegal code 3
    wr(2'd0, BASE,     32'h0100_0000, 4'b1000, "R6");
    wr(2'd0, BASE + 1, 32'h0100_0000, 4'b1000, "R6");
    wr(2'd0, 'h13, 32'hDEAD0000, 4'b1000, "R7");
    for (int t = 0; t < 4; t++) wr(2'(t), 'h13, 32'hBEEF0000 + t, 4'b1111, "R7");
    // back to CPU for group1
    wr(2'd0, BASE,     32'h0, 4'b0010, "R4");
    wr(2'd0, BASE + 1, 32'h0, 4'b0010, "R4");
    wr(2'd0, 'h14, 32'h12345678, 4'b0111, "R2");
    // random mix
    for (int i = 0; i < 300; i++) begin
      int sel;
      int a;
      sel = $urandom % 6;
      a = (sel == 0) ? BASE : (sel == 1) ? BASE + 1 : 'h10 + sel;
      wr(2'($urandom), a, DW'($urandom), LANES'($urandom), "R2");
    end
    @(negedge clk);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    wait (cycles > 20000);
    if (!done) begin
      done = 1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule